// File: doc/BRIEF.md
# Halt Standby Wakeup Controller

This block decides when a small microcontroller's CPU stops executing in the halt standby state and when it starts again. When the core raises a halt request while running, the block takes CPU operation to the halted state. The system clock keeps running during halt, and only instruction execution stops. While the core is halted, the block compares each interrupt request line with its mask bit and with the global interrupt-enable bit. From that comparison it chooses one of three outcomes: stay halted, resume at the next instruction, or enter interrupt servicing.

A reset input ends halt from any state. While reset is low the block is inactive. After reset is released, the block first waits for the oscillator to settle if the system clock comes from a crystal or ceramic resonator. That wait is 2^(base+select) cycles, where a 3-bit select input sets the exponent. The block then counts a fixed reset-processing hold period and lets the core run from its reset vector.

The core reads the outputs to gate execution. A one-cycle pulse on `resume_next` or on `take_interrupt` says which way the core must continue after a release from halt.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While halted, an interrupt request whose mask bit is 1 does not release halt. `in_halt` stays 1 and neither release pulse appears.
- R2: While halted, a request on any line whose mask bit is 0, with `int_en` = 0, releases halt. On the next cycle `cpu_run` = 1 and `resume_next` pulses, and `take_interrupt` stays 0.
- R3: While halted, an unmasked request with `int_en` = 1 releases halt. On the next cycle `cpu_run` = 1 and `take_interrupt` pulses, and `resume_next` stays 0.
- R4: A low `rst_n` ends halt or any other state at once. While it is low, `cpu_run`, `in_halt`, `stab_busy`, `rst_busy`, `resume_next` and `take_interrupt` are all 0. Reset wins over an interrupt that arrives in the same cycle, so no release pulse is produced.
- R5: If `xtal_sel` = 1 when reset is released, `stab_busy` is high for exactly 2^(STAB_BASE_EXP + `stab_sel`) cycles, starting one cycle after release. `stab_sel` is an unsigned value from 0 to 7.
- R6: If `xtal_sel` = 0 when reset is released, `stab_busy` never rises and the hold period starts one cycle after release.
- R7: `rst_busy` is high for exactly RST_HOLD_CYC cycles, right after the stabilization wait (or right after release when there is no wait). `cpu_run` rises on the cycle that follows.
- R8: A halt request sampled while `cpu_run` = 1 gives `in_halt` = 1 and `cpu_run` = 0 on the next cycle.
- R9: A halt request is ignored during the stabilization wait and the hold period. `cpu_run` still rises at the time given in R5 to R7 when the request is held high the whole time.
- R10: At most one of `cpu_run`, `in_halt`, `stab_busy` and `rst_busy` is 1 at any time.
- R11: A release pulse lasts one cycle, and `resume_next` and `take_interrupt` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, running in halt as well |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| xtal_sel | input | 1 | 1: clock comes from a crystal/ceramic resonator and needs a settle wait |
| stab_sel | input | 3 | Stabilization exponent offset added to STAB_BASE_EXP |
| halt_req | input | 1 | Halt request from the core |
| irq_req | input | N_SRC | Interrupt request lines |
| irq_mask | input | N_SRC | Per-line mask, 1 = masked |
| int_en | input | 1 | Global interrupt enable |
| cpu_run | output | 1 | Core may execute instructions |
| in_halt | output | 1 | Core is in halt standby |
| stab_busy | output | 1 | Oscillation stabilization wait in progress |
| rst_busy | output | 1 | Reset-processing hold in progress |
| resume_next | output | 1 | One-cycle pulse: continue at next instruction |
| take_interrupt | output | 1 | One-cycle pulse: begin interrupt servicing |

## Verification
The bench builds the block with N_SRC = 4, STAB_BASE_EXP = 2 and RST_HOLD_CYC = 5. With these values the whole range of `stab_sel` can be measured: the longest wait, 2^9 cycles, takes only a few hundred cycles. Four request lines are enough to show that a release can come from a single unmasked line among masked ones. The short hold period makes exact cycle counting possible from reset release to the first running cycle, for both clock-source settings.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

  typedef enum logic [2:0] {
    ST_RST  = 3'd0,
    ST_STAB = 3'd1,
    ST_HOLD = 3'd2,
    ST_RUN  = 3'd3,
    ST_HALT = 3'd4
  } wake_state_t;

  typedef enum logic [1:0] {
    REL_NONE   = 2'd0,
    REL_NEXT   = 2'd1,
    REL_VECTOR = 2'd2
  } rel_kind_t;

  // exponent of the stabilization length
  function automatic int unsigned stab_exp(input int unsigned base, input logic [2:0] sel);
    return base + int'(sel);
  endfunction

  // three-way release outcome
  function automatic rel_kind_t release_kind(input logic pend, input logic ie);
    if (!pend)    return REL_NONE;
    else if (ie)  return REL_VECTOR;
    else          return REL_NEXT;
  endfunction

endpackage

// File: rtl/halt_cycle_cnt.sv
module halt_cycle_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last_val;

  assign last_val = limit - W'(1);
  assign done     = en && (cnt_q == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!en)      cnt_q <= '0;
    else if (done)     cnt_q <= '0;
    else               cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/halt_release_eval.sv
module halt_release_eval
  import halt_wake_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_mask,
  input  logic             int_en,
  output logic             pend_any,
  output rel_kind_t        kind
);
  logic [N_SRC-1:0] live;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      assign live[g] = irq_req[g] & ~irq_mask[g];
    end
  endgenerate

  assign pend_any = |live;
  assign kind     = release_kind(pend_any, int_en);
endmodule

// File: rtl/halt_wake_fsm.sv
module halt_wake_fsm
  import halt_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xtal_i,
  input  logic        halt_req,
  input  logic        pend_any,
  input  rel_kind_t   kind,
  input  logic        stab_done,
  input  logic        hold_done,
  output wake_state_t state,
  output logic        pulse_next,
  output logic        pulse_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RST;
      pulse_next <= 1'b0;
      pulse_vec  <= 1'b0;
    end else begin
      pulse_next <= 1'b0;
      pulse_vec  <= 1'b0;
      case (state)
        ST_RST:  state <= xtal_i ? ST_STAB : ST_HOLD;
        ST_STAB: if (stab_done) state <= ST_HOLD;
        ST_HOLD: if (hold_done) state <= ST_RUN;
        ST_RUN:  if (halt_req)  state <= ST_HALT;
        ST_HALT: if (pend_any) begin
          state      <= ST_RUN;
          pulse_next <= (kind == REL_NEXT);
          pulse_vec  <= (kind == REL_VECTOR);
        end
        default: state <= ST_RST;
      endcase
    end
  end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
#(
  parameter int N_SRC         = 8,
  parameter int STAB_BASE_EXP = 10,
  parameter int RST_HOLD_CYC  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_sel,
  input  logic [2:0]       stab_sel,
  input  logic             halt_req,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_mask,
  input  logic             int_en,
  output logic             cpu_run,
  output logic             in_halt,
  output logic             stab_busy,
  output logic             rst_busy,
  output logic             resume_next,
  output logic             take_interrupt
);
  localparam int SW = STAB_BASE_EXP + 8;
  localparam int HW = $clog2(RST_HOLD_CYC + 1) + 1;

  wake_state_t state;
  rel_kind_t   kind;
  logic        pend_any;
  logic        stab_done, hold_done;
  logic [2:0]  sel_q;
  logic [SW-1:0] stab_limit;
  logic [HW-1:0] hold_limit;

  // capture the wait selection while reset processing begins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sel_q <= '0;
    else if (state == ST_RST)  sel_q <= stab_sel;
  end

  assign stab_limit = SW'(1) << stab_exp(STAB_BASE_EXP, sel_q);
  assign hold_limit = HW'(RST_HOLD_CYC);

  halt_release_eval #(.N_SRC(N_SRC)) u_eval (
    .irq_req (irq_req),
    .irq_mask(irq_mask),
    .int_en  (int_en),
    .pend_any(pend_any),
    .kind    (kind)
  );

  halt_cycle_cnt #(.W(SW)) u_stab (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state == ST_STAB),
    .limit(stab_limit),
    .done (stab_done)
  );

  halt_cycle_cnt #(.W(HW)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state == ST_HOLD),
    .limit(hold_limit),
    .done (hold_done)
  );

  halt_wake_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtal_i    (xtal_sel),
    .halt_req  (halt_req),
    .pend_any  (pend_any),
    .kind      (kind),
    .stab_done (stab_done),
    .hold_done (hold_done),
    .state     (state),
    .pulse_next(resume_next),
    .pulse_vec (take_interrupt)
  );

  assign cpu_run   = (state == ST_RUN);
  assign in_halt   = (state == ST_HALT);
  assign stab_busy = (state == ST_STAB);
  assign rst_busy  = (state == ST_HOLD);
endmodule

// File: rtl/halt_wake_chk.sv
module halt_wake_chk #(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xtal_sel,
  input logic             halt_req,
  input logic [N_SRC-1:0] irq_req,
  input logic [N_SRC-1:0] irq_mask,
  input logic             int_en,
  input logic             cpu_run,
  input logic             in_halt,
  input logic             stab_busy,
  input logic             rst_busy,
  input logic             resume_next,
  input logic             take_interrupt
);
  logic open_req;
  assign open_req = |(irq_req & ~irq_mask);

  AST_MASKED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    in_halt && !open_req |=> in_halt && !resume_next && !take_interrupt); // R1
  AST_RESUME_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_halt && open_req && !int_en |=> cpu_run && resume_next && !take_interrupt); // R2
  AST_VECTOR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_halt && open_req && int_en |=> cpu_run && take_interrupt && !resume_next); // R3
  AST_NO_WAIT_RC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stab_busy) |-> $past(xtal_sel)); // R6
  AST_HOLD_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stab_busy) |-> rst_busy); // R5
  AST_RUN_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy) |-> cpu_run); // R7
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run && halt_req |=> in_halt && !cpu_run); // R8
  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_run, in_halt, stab_busy, rst_busy})); // R10
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_next || take_interrupt) |=> !resume_next && !take_interrupt); // R11
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(resume_next && take_interrupt)); // R11
endmodule

bind halt_wake_ctrl halt_wake_chk #(.N_SRC(N_SRC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xtal_sel      (xtal_sel),
  .halt_req      (halt_req),
  .irq_req       (irq_req),
  .irq_mask      (irq_mask),
  .int_en        (int_en),
  .cpu_run       (cpu_run),
  .in_halt       (in_halt),
  .stab_busy     (stab_busy),
  .rst_busy      (rst_busy),
  .resume_next   (resume_next),
  .take_interrupt(take_interrupt)
);

// File: tb/sim_halt_wake_ctrl.sv
`timescale 1ns/1ps
module sim_halt_wake_ctrl;
  localparam int NS   = 4;
  localparam int BASE = 2;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_sel = 1'b0;
  logic [2:0] stab_sel = '0;
  logic halt_req = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic [NS-1:0] irq_mask = '0;
  logic int_en = 1'b0;
  logic cpu_run, in_halt, stab_busy, rst_busy, resume_next, take_interrupt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  halt_wake_ctrl #(.N_SRC(NS), .STAB_BASE_EXP(BASE), .RST_HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .xtal_sel(xtal_sel), .stab_sel(stab_sel),
    .halt_req(halt_req), .irq_req(irq_req), .irq_mask(irq_mask), .int_en(int_en),
    .cpu_run(cpu_run), .in_halt(in_halt), .stab_busy(stab_busy), .rst_busy(rst_busy),
    .resume_next(resume_next), .take_interrupt(take_interrupt)
  );

  // {req[3:0], mask[3:0], int_en, outcome[1:0]}; outcome 0 stay, 1 next, 2 vector
  localparam logic [10:0] VEC [8] = '{
    {4'b0001, 4'b0001, 1'b0, 2'd0},
    {4'b0001, 4'b0000, 1'b0, 2'd1},
    {4'b0001, 4'b0000, 1'b1, 2'd2},
    {4'b1000, 4'b0111, 1'b1, 2'd2},
    {4'b0110, 4'b0110, 1'b1, 2'd0},
    {4'b0000, 4'b0000, 1'b1, 2'd0},
    {4'b0101, 4'b0100, 1'b0, 2'd1},
    {4'b1111, 4'b1111, 1'b0, 2'd0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {2'b00, cpu_run, in_halt, stab_busy, rst_busy, resume_next, take_interrupt};
  endfunction

  // reset then count cycles to first run; returns cycles, stab count, hold count
  task automatic boot(input logic xt, input logic [2:0] sel, input logic hreq,
                      output int cyc, output int nst, output int nho);
    @(negedge clk);
    rst_n = 1'b0; xtal_sel = xt; stab_sel = sel; halt_req = hreq;
    irq_req = '0; irq_mask = '0; int_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R4 reset outputs", outs(), 8'h00);
    rst_n = 1'b1;
    cyc = 0; nst = 0; nho = 0;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (stab_busy) nst++;
      if (rst_busy)  nho++;
      if (cpu_run) break;
    end
    halt_req = 1'b0;
  endtask

  task automatic enter_halt();
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
    check("R8 halt entry", {6'b0, cpu_run, in_halt}, 8'h01);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc, nst, nho;
    logic [7:0] exp_o;

    // R6, R7: internal clock source, no settle wait
    boot(1'b0, 3'd3, 1'b0, cyc, nst, nho);
    check("R6 boot cycles rc", 8'(cyc), 8'(1 + HOLD));
    check("R6 no stab wait", 8'(nst), 8'd0);
    check("R7 hold length", 8'(nho), 8'(HOLD));

    // vector table walk: R1, R2, R3
    foreach (VEC[i]) begin
      enter_halt();
      irq_req = VEC[i][10:7]; irq_mask = VEC[i][6:3]; int_en = VEC[i][2];
      @(negedge clk);
      case (VEC[i][1:0])
        2'd0:    exp_o = 8'b00_0100_00;
        2'd1:    exp_o = 8'b00_1000_10;
        default: exp_o = 8'b00_1000_01;
      endcase
      check(VEC[i][1:0] == 2'd0 ? "R1 masked stays" :
            (VEC[i][1:0] == 2'd1 ? "R2 resume next" : "R3 vector"), outs(), exp_o);
      irq_req = '0;
      if (VEC[i][1:0] == 2'd0) begin
        irq_req = 4'b0010; irq_mask = '0; int_en = 1'b0;
        @(negedge clk);
        irq_req = '0;
      end
      @(negedge clk);
      check("R11 pulse one cycle", outs(), 8'b00_1000_00);
    end

    // R4: reset and interrupt together while halted
    enter_halt();
    irq_mask = '0; int_en = 1'b1; irq_req = 4'b0100;
    rst_n = 1'b0;
    #1;
    check("R4 reset wins async", outs(), 8'h00);
    @(negedge clk);
    check("R4 reset wins clocked", outs(), 8'h00);

    // R5: crystal source, shortest and longest waits
    boot(1'b1, 3'd0, 1'b0, cyc, nst, nho);
    check("R5 stab len sel0", 8'(nst), 8'(1 << BASE));
    check("R5 boot cycles sel0", 8'(cyc), 8'(1 + (1 << BASE) + HOLD));
    boot(1'b1, 3'd7, 1'b0, cyc, nst, nho);
    check("R5 stab len sel7 lo", 8'(nst), 8'((1 << (BASE + 7)) & 255));
    check("R5 stab len sel7 hi", 8'(nst >> 8), 8'((1 << (BASE + 7)) >> 8));
    check("R7 hold after wait", 8'(nho), 8'(HOLD));
    check("R5 boot cycles sel7", 8'((cyc - 1 - HOLD) >> 8), 8'((1 << (BASE + 7)) >> 8));

    // R9: halt request held through the whole sequence
    boot(1'b1, 3'd1, 1'b1, cyc, nst, nho);
    check("R9 halt ignored during boot", 8'(cyc), 8'(1 + (1 << (BASE + 1)) + HOLD));
    check("R10 single state at run", outs(), 8'b00_1000_00);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule